// File: doc/BRIEF.md
# SPI Channel FIFO, Status and Interrupt Unit

This unit sits between the register bus of one SPI channel and its shift engine. It holds two 8-word FIFOs of 32-bit data. Software writes the transmit FIFO through a data register and the engine drains it. The engine fills the receive FIFO and software drains it through a second data register. A word-count register reports how full each FIFO is. A threshold register sets the level at which each FIFO asks for service.

Events come from the engine or arise from FIFO levels: transfer pending, transfer done, transmit threshold, receive threshold, transmit underflow and receive overflow. Each event latches into a sticky status bit, and software clears a bit by writing a one to it. An interrupt-enable register masks the status bits onto a single level interrupt line. The register bus uses byte offsets. The unit decodes only the offsets it owns, so the channel's configuration, divider and command registers can live in a neighbouring block at the usual offsets 0x00, 0x04 and 0x08.

Top module: `spi_fifo_stat_unit`

## Requirements
- R1: A one-cycle pulse on `eng_pend_i` sets status bit 0, and a pulse on `eng_done_i` sets status bit 1. The status register sits at offset 0x0C, its bits [5:0] are meaningful and its upper bits read 0. A status bit stays set until software clears it.
- R2: A write to offset 0x0C clears each status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R3: When an event sets a status bit in the same cycle as a write-one clear of that bit, the bit ends up set.
- R4: The word-count register at offset 0x18 reads the receive FIFO occupancy (0 to 8) in bits [3:0] and the transmit FIFO occupancy in bits [7:4].
- R5: Words written to offset 0x1C leave in write order at `eng_tx_data_o`, one per `eng_tx_pop_i`. Words pushed with `eng_rx_push_i` read back in push order from offset 0x20. Each read of 0x20 with `reg_re_i` set removes one word.
- R6: A write to offset 0x1C while the transmit FIFO holds 8 words is dropped, and the occupancy stays 8.
- R7: A receive push while the receive FIFO holds 8 words is dropped and sets status bit 5. A read of offset 0x20 while the receive FIFO is empty returns 0.
- R8: An `eng_tx_pop_i` while the transmit FIFO is empty sets status bit 4, and `eng_tx_valid_o` is 0 while the transmit FIFO is empty.
- R9: The threshold register at offset 0x14 reads back what was written. Bits [3:0] hold the transmit level and bits [7:4] the receive level. Status bit 2 sets while transmit occupancy is at or below the transmit level. Status bit 3 sets while receive occupancy is at or above the receive level.
- R10: The interrupt-enable register at offset 0x10 maps each enable bit to one status bit: enable bit 0 to done (status 1), bit 1 to status 2, bit 2 to status 3, bit 3 to status 4 and bit 4 to status 5. `irq_o` is high exactly when some enabled status bit is set.
- R11: After reset the word-count and interrupt-enable registers read 0, the threshold levels are 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops the receive FIFO at 0x20) |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the offset |
| eng_pend_i | input | 1 | Engine pulse: transfer pending |
| eng_done_i | input | 1 | Engine pulse: transfer done |
| eng_tx_pop_i | input | 1 | Engine takes the head transmit word |
| eng_tx_data_o | output | 32 | Head transmit word |
| eng_tx_valid_o | output | 1 | Transmit FIFO not empty |
| eng_rx_push_i | input | 1 | Engine delivers a received word |
| eng_rx_data_i | input | 32 | Received word |
| irq_o | output | 1 | Level interrupt |

## Verification
Register writes, FIFO pushes and pops, engine pulses, error flags and write-one clears all take effect at the clock edge that samples the strobe. The bench drives strobes at the falling edge and reads back or samples outputs at the next falling edge, one rising edge later. Threshold status follows the occupancy with one more edge of delay, so threshold checks are made only after several idle edges. Read data is combinational, so a receive-data read is sampled before the rising edge that pops the word. `irq_o` is combinational from the status and enable registers and is checked at the falling edge after the change.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int unsigned AW = 8;
  localparam logic [AW-1:0] OFS_STAT = 8'h0C;
  localparam logic [AW-1:0] OFS_IE   = 8'h10;
  localparam logic [AW-1:0] OFS_THR  = 8'h14;
  localparam logic [AW-1:0] OFS_WCNT = 8'h18;
  localparam logic [AW-1:0] OFS_TXD  = 8'h1C;
  localparam logic [AW-1:0] OFS_RXD  = 8'h20;
  localparam int unsigned NSTAT = 6;
  localparam int unsigned NIE   = 5;
  localparam int unsigned S_PEND = 0;
  localparam int unsigned S_DONE = 1;
  localparam int unsigned S_TXTH = 2;
  localparam int unsigned S_RXTH = 3;
  localparam int unsigned S_TXUF = 4;
  localparam int unsigned S_RXOF = 5;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;
  assign data_o  = empty_o ? '0 : mem_q[rd_q];
  assign count_o = cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  // R6 / R7: a push into a full FIFO without a pop leaves occupancy alone
  p_full_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> $stable(cnt_q));
endmodule

// File: rtl/spi_fifo_status.sv
module spi_fifo_status
  import spi_fifo_pkg::*;
#(
  parameter int unsigned CW = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_we_i,
  input  logic [NSTAT-1:0] clr_i,
  input  logic            ie_we_i,
  input  logic [NIE-1:0]  ie_i,
  input  logic            thr_we_i,
  input  logic [2*CW-1:0] thr_i,
  input  logic            pend_i,
  input  logic            done_i,
  input  logic            tx_uf_i,
  input  logic            rx_of_i,
  input  logic [CW-1:0]   tx_cnt_i,
  input  logic [CW-1:0]   rx_cnt_i,
  output logic [NSTAT-1:0] stat_o,
  output logic [NIE-1:0]  ie_o,
  output logic [2*CW-1:0] thr_o,
  output logic            irq_o
);
  logic [NSTAT-1:0] stat_q, set_v, clr_v;
  logic [NIE-1:0]   ie_q;
  logic [2*CW-1:0]  thr_q;
  logic [CW-1:0]    tx_lvl, rx_lvl;

  assign tx_lvl = thr_q[CW-1:0];
  assign rx_lvl = thr_q[2*CW-1:CW];

  always_comb begin
    set_v         = '0;
    set_v[S_PEND] = pend_i;
    set_v[S_DONE] = done_i;
    set_v[S_TXTH] = (tx_cnt_i <= tx_lvl);
    set_v[S_RXTH] = (rx_cnt_i >= rx_lvl);
    set_v[S_TXUF] = tx_uf_i;
    set_v[S_RXOF] = rx_of_i;
    clr_v         = clr_we_i ? clr_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      ie_q   <= '0;
      thr_q  <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_v) | set_v;  // set wins over clear
      if (ie_we_i)  ie_q  <= ie_i;
      if (thr_we_i) thr_q <= thr_i;
    end
  end

  // enable bit k guards status bit k+1
  assign irq_o  = |(stat_q[NSTAT-1:1] & ie_q);
  assign stat_o = stat_q;
  assign ie_o   = ie_q;
  assign thr_o  = thr_q;

  p_done_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> stat_q[S_DONE]);
  p_w1c_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && clr_i[S_PEND] && !pend_i) |=> !stat_q[S_PEND]);
  p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[S_TXUF] && !(clr_we_i && clr_i[S_TXUF])) |=> stat_q[S_TXUF]);
  p_irq_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat_q[NSTAT-1:1] != '0) && (ie_q != '0));
endmodule

// File: rtl/spi_fifo_stat_unit.sv
module spi_fifo_stat_unit
  import spi_fifo_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          eng_pend_i,
  input  logic          eng_done_i,
  input  logic          eng_tx_pop_i,
  output logic [DW-1:0] eng_tx_data_o,
  output logic          eng_tx_valid_o,
  input  logic          eng_rx_push_i,
  input  logic [DW-1:0] eng_rx_data_i,
  output logic          irq_o
);
  logic [CW-1:0]    tx_cnt, rx_cnt;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [DW-1:0]    rx_head;
  logic [NSTAT-1:0] stat;
  logic [NIE-1:0]   ie;
  logic [2*CW-1:0]  thr;
  logic             wr_txd, rd_rxd, wr_stat, wr_ie, wr_thr;

  assign wr_txd  = reg_we_i && (reg_addr_i == OFS_TXD);
  assign wr_stat = reg_we_i && (reg_addr_i == OFS_STAT);
  assign wr_ie   = reg_we_i && (reg_addr_i == OFS_IE);
  assign wr_thr  = reg_we_i && (reg_addr_i == OFS_THR);
  assign rd_rxd  = reg_re_i && (reg_addr_i == OFS_RXD);

  spi_word_fifo #(.W(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(wr_txd), .data_i(reg_wdata_i[DW-1:0]),
    .pop_i(eng_tx_pop_i), .data_o(eng_tx_data_o),
    .count_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty)
  );

  spi_word_fifo #(.W(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(eng_rx_push_i), .data_i(eng_rx_data_i),
    .pop_i(rd_rxd), .data_o(rx_head),
    .count_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty)
  );

  spi_fifo_status #(.CW(CW)) u_status (
    .clk_i, .rst_ni,
    .clr_we_i(wr_stat), .clr_i(reg_wdata_i[NSTAT-1:0]),
    .ie_we_i(wr_ie), .ie_i(reg_wdata_i[NIE-1:0]),
    .thr_we_i(wr_thr), .thr_i(reg_wdata_i[2*CW-1:0]),
    .pend_i(eng_pend_i), .done_i(eng_done_i),
    .tx_uf_i(eng_tx_pop_i & tx_empty), .rx_of_i(eng_rx_push_i & rx_full),
    .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt),
    .stat_o(stat), .ie_o(ie), .thr_o(thr), .irq_o(irq_o)
  );

  assign eng_tx_valid_o = ~tx_empty;

  always_comb begin
    case (reg_addr_i)
      OFS_STAT: reg_rdata_o = 32'(stat);
      OFS_IE:   reg_rdata_o = 32'(ie);
      OFS_THR:  reg_rdata_o = 32'(thr);
      OFS_WCNT: reg_rdata_o = 32'({tx_cnt, rx_cnt});
      OFS_RXD:  reg_rdata_o = 32'(rx_head);
      default:  reg_rdata_o = '0;
    endcase
  end

  p_rx_of_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_rx_push_i && rx_full) |=> stat[S_RXOF]);
  p_tx_uf_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_tx_pop_i && !eng_tx_valid_o) |=> stat[S_TXUF]);
  p_rx_empty_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == OFS_RXD && rx_cnt == '0) |-> reg_rdata_o == '0);
endmodule

// File: tb/tb_spi_fifo_stat_unit.sv
`timescale 1ns/1ps
module tb_spi_fifo_stat_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 0, re = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        pend = 0, done = 0, tx_pop = 0, rx_push = 0;
  logic [31:0] tx_data, rx_data = 0;
  logic        tx_valid, irq;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  spi_fifo_stat_unit dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .eng_pend_i(pend), .eng_done_i(done),
    .eng_tx_pop_i(tx_pop), .eng_tx_data_o(tx_data), .eng_tx_valid_o(tx_valid),
    .eng_rx_push_i(rx_push), .eng_rx_data_i(rx_data),
    .irq_o(irq)
  );

  // vector: {is_read, offset, data (write) or expected (read), requirement}
  localparam int NV = 22;
  localparam logic [44:0] VEC [NV] = '{
    {1'b1, 8'h18, 32'h0000_0000, 4'd11},  // R11 counts zero
    {1'b1, 8'h10, 32'h0000_0000, 4'd11},  // R11 enables zero
    {1'b1, 8'h14, 32'h0000_0000, 4'd11},  // R11 levels zero
    {1'b1, 8'h0C, 32'h0000_000C, 4'd9},   // R9 both level conditions hold at 0
    {1'b0, 8'h14, 32'h0000_0023, 4'd9},
    {1'b1, 8'h14, 32'h0000_0023, 4'd9},   // R9 readback
    {1'b0, 8'h0C, 32'h0000_003F, 4'd3},
    {1'b1, 8'h0C, 32'h0000_0004, 4'd3},   // R3 tx level still met
    {1'b0, 8'h1C, 32'hA000_0001, 4'd5},
    {1'b0, 8'h1C, 32'hA000_0002, 4'd5},
    {1'b0, 8'h1C, 32'hA000_0003, 4'd5},
    {1'b0, 8'h1C, 32'hA000_0004, 4'd5},
    {1'b1, 8'h18, 32'h0000_0040, 4'd4},   // R4 tx count in [7:4]
    {1'b0, 8'h0C, 32'h0000_0004, 4'd2},
    {1'b1, 8'h0C, 32'h0000_0000, 4'd2},   // R2 cleared, 4 > level 3
    {1'b0, 8'h1C, 32'hA000_0005, 4'd5},
    {1'b0, 8'h1C, 32'hA000_0006, 4'd5},
    {1'b0, 8'h1C, 32'hA000_0007, 4'd5},
    {1'b0, 8'h1C, 32'hA000_0008, 4'd5},
    {1'b0, 8'h1C, 32'hDEAD_BEEF, 4'd6},   // R6 dropped
    {1'b1, 8'h18, 32'h0000_0080, 4'd6},   // R6 count stays 8
    {1'b0, 8'h10, 32'h0000_0002, 4'd10}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic reg_rd(input logic [7:0] a, input logic pop, output logic [31:0] d);
    @(negedge clk); addr = a; re = pop;
    #1 d = rdata;
    @(negedge clk); re = 0;
  endtask

  task automatic pulse_pend();
    @(negedge clk); pend = 1; @(negedge clk); pend = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1; @(negedge clk); done = 0;
  endtask

  task automatic rx_in(input logic [31:0] d);
    @(negedge clk); rx_push = 1; rx_data = d; @(negedge clk); rx_push = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    check("R11 irq in reset", {31'b0, irq}, 32'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R11 irq after reset", {31'b0, irq}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][44]) begin
        reg_rd(VEC[i][43:36], 1'b0, v);
        check($sformatf("R%0d vector %0d", VEC[i][3:0], i), v, VEC[i][35:4]);
      end else begin
        reg_wr(VEC[i][43:36], VEC[i][35:4]);
      end
    end

    check("R10 irq masked, tx above level", {31'b0, irq}, 32'd0);
    // R5 drain in order
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      check("R5 tx order", tx_data, 32'hA000_0000 | k);
      tx_pop = 1;
      @(negedge clk); tx_pop = 0;
    end
    repeat (2) @(negedge clk);
    check("R8 tx valid low when empty", {31'b0, tx_valid}, 32'd0);
    check("R10 tx threshold irq", {31'b0, irq}, 32'd1);
    @(negedge clk); tx_pop = 1; @(negedge clk); tx_pop = 0;  // R8 underflow
    reg_rd(8'h0C, 1'b0, v);
    check("R8 underflow status", v, 32'h14);
    reg_wr(8'h10, 32'h08);
    check("R10 underflow enable", {31'b0, irq}, 32'd1);
    reg_wr(8'h10, 32'h10);
    check("R10 overflow enable, no overflow", {31'b0, irq}, 32'd0);
    reg_wr(8'h10, 32'h00);
    reg_wr(8'h0C, 32'h3F);

    // R1 engine events
    pulse_pend();
    reg_rd(8'h0C, 1'b0, v);
    check("R1 pending", v, 32'h05);
    pulse_done();
    reg_rd(8'h0C, 1'b0, v);
    check("R1 done", v, 32'h07);
    reg_wr(8'h10, 32'h01);
    check("R10 done enable maps to status 1", {31'b0, irq}, 32'd1);
    reg_wr(8'h10, 32'h00);
    reg_wr(8'h0C, 32'h01);
    reg_rd(8'h0C, 1'b0, v);
    check("R2 clear pending only", v, 32'h06);
    reg_wr(8'h0C, 32'h02);
    reg_rd(8'h0C, 1'b0, v);
    check("R2 clear done", v, 32'h04);
    // R3 same-cycle set and clear
    @(negedge clk); we = 1; addr = 8'h0C; wdata = 32'h02; done = 1;
    @(negedge clk); we = 0; done = 0;
    reg_rd(8'h0C, 1'b0, v);
    check("R3 set wins", v, 32'h06);
    reg_wr(8'h0C, 32'h3F);

    // RX path
    for (int k = 0; k < 8; k++) rx_in(32'hB000_0000 | k);
    reg_rd(8'h18, 1'b0, v);
    check("R4 rx count in [3:0]", v, 32'h08);
    rx_in(32'h0BAD_0BAD);
    reg_rd(8'h18, 1'b0, v);
    check("R7 overflow word dropped", v, 32'h08);
    reg_rd(8'h0C, 1'b0, v);
    check("R7 overflow and R9 rx level status", v, 32'h2C);
    for (int k = 0; k < 8; k++) begin
      reg_rd(8'h20, 1'b1, v);
      check("R5 rx order", v, 32'hB000_0000 | k);
    end
    reg_rd(8'h20, 1'b1, v);
    check("R7 empty read returns zero", v, 32'h0);
    reg_rd(8'h18, 1'b0, v);
    check("R4 counts back to zero", v, 32'h0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule